// File: doc/BRIEF.md
# Line Switch State Controller

This block is the digital control core of a solid-state line-card switch that takes the place of a pair of electromechanical relays. Two command bits, a ring select and an access select, choose one of four line states. The block turns that choice into enable signals for six switches: a tip/ring break pair toward the subscriber interface circuit, a ring return switch, a ring access switch toward the ring generator, and a tip/ring test access pair.

Several conditions sit above the command path. A hold input freezes the commands. An active-low override forces every switch off and is not affected by the hold. A thermal fault forces all off and pulls a status output low. A battery monitor with hysteresis keeps the line off until the battery is known to be valid. The ring access switch can only open on a ring-current zero-crossing strobe, so leaving the ringing state gives make-before-break behaviour. When a forcing condition goes away, the switches return to the state the commands select.

Top module: `lsw_ctrl`

## Requirements
- R1: The command is {ring_sel_i, acc_sel_i}. 00 is idle/talk and enables both break switches, so sw_en_o = 0x03. 10 is ringing and enables ring return and ring access, so sw_en_o = 0x0C. 01 is test access and enables both test access switches, so sw_en_o = 0x30. The bits of sw_en_o are: bit0 tip break, bit1 ring break, bit2 ring return, bit3 ring access, bit4 tip test access, bit5 ring test access.
- R2: A switch that the selected state does not name is off. Command 11 turns every switch off (sw_en_o = 0x00).
- R3: While hold_i is low, command changes pass to the switches. While hold_i is high, the switches keep the command captured when hold_i rose, and later command changes have no effect until hold_i falls.
- R4: ovr_n_i low forces every switch off, whatever the command and whatever hold_i is doing. The only exception is a ring access switch that is already on, which follows R5. When ovr_n_i returns high, the switches follow the command again.
- R5: Once the ring access switch (bit3) is on, it turns off only in the cycle after a zc_i strobe arrives while its off condition holds. Until then it stays on, whatever the commands or forcing conditions are.
- R6: On leaving ringing, the ring return switch (bit2) opens at once. The new state's switches, for example the break pair, turn on while bit3 is still waiting for its zero crossing.
- R7: bat_high_i or bat_lost_i forces all off. All off is then held, even after both flags drop, until bat_ok_i is seen with neither of them asserted.
- R8: With THERM_EN = 1, therm_i high forces all off and drives sd_status_o low. sd_status_o is high otherwise. When therm_i clears, the switches return to the commanded state.
- R9: With THERM_EN = 0, therm_i has no effect: the switches follow the command and sd_status_o stays high.
- R10: After reset, sw_en_o is 0x00 and sd_status_o is 1. The line stays all off, whatever the command, until bat_ok_i has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_sel_i | input | 1 | Ring select command bit (asynchronous) |
| acc_sel_i | input | 1 | Access select command bit (asynchronous) |
| hold_i | input | 1 | Command hold; high freezes the command (asynchronous) |
| ovr_n_i | input | 1 | Active-low force-off override (asynchronous) |
| therm_i | input | 1 | Thermal fault flag (asynchronous) |
| bat_high_i | input | 1 | Battery above the upper threshold (asynchronous) |
| bat_lost_i | input | 1 | Battery lost (asynchronous) |
| bat_ok_i | input | 1 | Battery below the lower threshold, valid (asynchronous) |
| zc_i | input | 1 | Ring-current zero-crossing strobe, one cycle, clock domain |
| sw_en_o | output | 6 | Switch enables, bit map in R1 |
| sd_status_o | output | 1 | High in normal operation, low during thermal shutdown |

## Verification
The assertions assume that zc_i is a clean one-cycle pulse already in the clock domain. They also assume the other inputs are slow levels that pass through the two-flop synchronisers, so each property is written against the synchronised copies, one register before the switch outputs. The stimulus drives every input on the falling clock edge. Each level is held for several cycles before the outputs are sampled. zc_i is pulsed for exactly one cycle and only when the state is steady. The battery flags never carry conflicting values at the same time.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    localparam int SW_W   = 6;
    localparam int SYNC_W = 8;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_TEST = 2'b01,
        CMD_RING = 2'b10,
        CMD_OFF  = 2'b11
    } cmd_e;

    // bit5 .. bit0
    typedef struct packed {
        logic rt_acc;   // ring test access
        logic tp_acc;   // tip test access
        logic rg_acc;   // ring access (zero-cross release)
        logic rg_ret;   // ring return
        logic rg_brk;   // ring break
        logic tp_brk;   // tip break
    } sw_t;

    // synchroniser lane positions
    localparam int L_RING  = 0;
    localparam int L_ACC   = 1;
    localparam int L_HOLD  = 2;
    localparam int L_OVRN  = 3;
    localparam int L_THERM = 4;
    localparam int L_BHIGH = 5;
    localparam int L_BLOST = 6;
    localparam int L_BOK   = 7;

    function automatic sw_t decode_cmd(input cmd_e c);
        sw_t s;
        s = '0;
        unique case (c)
            CMD_IDLE: begin s.tp_brk = 1'b1; s.rg_brk = 1'b1; end
            CMD_RING: begin s.rg_ret = 1'b1; s.rg_acc = 1'b1; end
            CMD_TEST: begin s.tp_acc = 1'b1; s.rt_acc = 1'b1; end
            default:  s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lsw_sync.sv
module lsw_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= RST_VAL;
                else if (g == 0) chain_q[g] <= d_i;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lsw_latch.sv
module lsw_latch
    import lsw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  cmd_e cmd_i,
    output cmd_e cmd_o
);
    cmd_e held_q;

    assign cmd_o = hold_i ? held_q : cmd_i;

    always_ff @(posedge clk) begin
        if (rst) held_q <= CMD_OFF;
        else     held_q <= cmd_o;
    end

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (hold_i && $past(hold_i)) |-> (cmd_o == $past(cmd_o)));
endmodule

// File: rtl/lsw_guard.sv
module lsw_guard #(
    parameter bit THERM_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ovr_n_i,
    input  logic therm_i,
    input  logic bat_high_i,
    input  logic bat_lost_i,
    input  logic bat_ok_i,
    output logic force_off_o,
    output logic sd_status_o
);
    logic bat_block_q;
    logic therm_act;
    logic bat_bad;

    assign bat_bad   = bat_high_i | bat_lost_i;
    assign therm_act = THERM_EN ? therm_i : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            bat_block_q <= 1'b1;
            sd_status_o <= 1'b1;
        end else begin
            if (bat_bad)       bat_block_q <= 1'b1;
            else if (bat_ok_i) bat_block_q <= 1'b0;
            sd_status_o <= ~therm_act;
        end
    end

    assign force_off_o = bat_block_q | therm_act | ~ovr_n_i;

    a_r7_bad_blocks: assert property (@(posedge clk) disable iff (rst)
        bat_bad |=> bat_block_q);
    a_r7_block_sticky: assert property (@(posedge clk) disable iff (rst)
        (bat_block_q && !bat_ok_i) |=> bat_block_q);
    a_r8_status_low: assert property (@(posedge clk) disable iff (rst)
        (THERM_EN && therm_i) |=> !sd_status_o);
    a_r9_status_high: assert property (@(posedge clk) disable iff (rst)
        (!THERM_EN) |=> sd_status_o);
endmodule

// File: rtl/lsw_switch.sv
module lsw_switch
    import lsw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd_i,
    input  logic force_off_i,
    input  logic zc_i,
    output sw_t  sw_o
);
    sw_t tgt;
    sw_t nxt;

    always_comb begin
        tgt = force_off_i ? sw_t'('0) : decode_cmd(cmd_i);
        nxt = tgt;
        nxt.rg_acc = tgt.rg_acc | (sw_o.rg_acc & ~zc_i);
    end

    always_ff @(posedge clk) begin
        if (rst) sw_o <= '0;
        else     sw_o <= nxt;
    end

    a_r5_wait_zc: assert property (@(posedge clk) disable iff (rst)
        (sw_o.rg_acc && !zc_i) |=> sw_o.rg_acc);
    a_r4_forced_off: assert property (@(posedge clk) disable iff (rst)
        force_off_i |=> (!sw_o.tp_brk && !sw_o.rg_brk && !sw_o.rg_ret &&
                         !sw_o.tp_acc && !sw_o.rt_acc));
    a_r4_no_new_ring: assert property (@(posedge clk) disable iff (rst)
        (force_off_i && !sw_o.rg_acc) |=> !sw_o.rg_acc);
    a_r2_one_group: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sw_o.tp_brk, sw_o.rg_ret, sw_o.tp_acc}));
endmodule

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
    import lsw_pkg::*;
#(
    parameter bit THERM_EN    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ring_sel_i,
    input  logic            acc_sel_i,
    input  logic            hold_i,
    input  logic            ovr_n_i,
    input  logic            therm_i,
    input  logic            bat_high_i,
    input  logic            bat_lost_i,
    input  logic            bat_ok_i,
    input  logic            zc_i,
    output logic [SW_W-1:0] sw_en_o,
    output logic            sd_status_o
);
    localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << L_OVRN;

    logic [SYNC_W-1:0] raw, syn;
    cmd_e cmd_s, cmd_l;
    logic force_off;
    sw_t  sw;

    always_comb begin
        raw          = '0;
        raw[L_RING]  = ring_sel_i;
        raw[L_ACC]   = acc_sel_i;
        raw[L_HOLD]  = hold_i;
        raw[L_OVRN]  = ovr_n_i;
        raw[L_THERM] = therm_i;
        raw[L_BHIGH] = bat_high_i;
        raw[L_BLOST] = bat_lost_i;
        raw[L_BOK]   = bat_ok_i;
    end

    lsw_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
        .clk(clk), .rst(rst), .d_i(raw), .q_o(syn)
    );

    assign cmd_s = cmd_e'({syn[L_RING], syn[L_ACC]});

    lsw_latch latch_i (
        .clk(clk), .rst(rst), .hold_i(syn[L_HOLD]), .cmd_i(cmd_s), .cmd_o(cmd_l)
    );

    lsw_guard #(.THERM_EN(THERM_EN)) guard_i (
        .clk(clk), .rst(rst),
        .ovr_n_i(syn[L_OVRN]), .therm_i(syn[L_THERM]),
        .bat_high_i(syn[L_BHIGH]), .bat_lost_i(syn[L_BLOST]), .bat_ok_i(syn[L_BOK]),
        .force_off_o(force_off), .sd_status_o(sd_status_o)
    );

    lsw_switch switch_i (
        .clk(clk), .rst(rst), .cmd_i(cmd_l), .force_off_i(force_off),
        .zc_i(zc_i), .sw_o(sw)
    );

    assign sw_en_o = sw;

    a_r4_override: assert property (@(posedge clk) disable iff (rst)
        !syn[L_OVRN] |=> ((sw_en_o & 6'b110111) == 6'b0));
    a_r6_return_opens: assert property (@(posedge clk) disable iff (rst)
        (!force_off && cmd_l != CMD_RING) |=> !sw_en_o[2]);
endmodule

// File: tb/lsw_ctrl_tb_top.sv
module lsw_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ring_sel = 0, acc_sel = 0, hold = 0, ovr_n = 1, therm = 0;
    logic bat_high = 0, bat_lost = 0, bat_ok = 0, zc = 0;
    logic [5:0] sw, sw_nt;
    logic sd, sd_nt;

    int n_chk = 0;
    int n_err = 0;
    logic [6:0] exp_q[$];
    string      tag_q[$];
    event       chk_ev;

    always #4 clk = ~clk;

    lsw_ctrl dut_i (
        .clk(clk), .rst(rst), .ring_sel_i(ring_sel), .acc_sel_i(acc_sel),
        .hold_i(hold), .ovr_n_i(ovr_n), .therm_i(therm), .bat_high_i(bat_high),
        .bat_lost_i(bat_lost), .bat_ok_i(bat_ok), .zc_i(zc),
        .sw_en_o(sw), .sd_status_o(sd)
    );

    lsw_ctrl #(.THERM_EN(1'b0)) dut_nt (
        .clk(clk), .rst(rst), .ring_sel_i(ring_sel), .acc_sel_i(acc_sel),
        .hold_i(hold), .ovr_n_i(ovr_n), .therm_i(therm), .bat_high_i(bat_high),
        .bat_lost_i(bat_lost), .bat_ok_i(bat_ok), .zc_i(zc),
        .sw_en_o(sw_nt), .sd_status_o(sd_nt)
    );

    task automatic compare(input logic [6:0] act, input logic [6:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual sw=%h sd=%b expected sw=%h sd=%b",
                     tag, act[6:1], act[0], exp[6:1], exp[0]);
        end
    endtask

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                logic [6:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compare({sw, sd}, e, t);
            end
        end
    end

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input logic [5:0] s, input logic d, input string tag);
        exp_q.push_back({s, d});
        tag_q.push_back(tag);
        -> chk_ev;
        #1;
    endtask

    task automatic set_cmd(input logic r, input logic a);
        ring_sel = r; acc_sel = a;
        settle();
    endtask

    task automatic pulse_zc();
        zc = 1'b1;
        @(negedge clk);
        zc = 1'b0;
        settle();
    endtask

    task automatic pulse_ok();
        bat_ok = 1'b1; settle();
        bat_ok = 1'b0; settle();
    endtask

    initial begin
        #400000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_out(6'h00, 1'b1, "R10 reset state");
        set_cmd(0, 0);
        expect_out(6'h00, 1'b1, "R10 off until battery valid");
        pulse_ok();
        expect_out(6'h03, 1'b1, "R1 idle/talk");
        set_cmd(0, 1);
        expect_out(6'h30, 1'b1, "R1 test access");
        set_cmd(1, 1);
        expect_out(6'h00, 1'b1, "R2 all off command");
        set_cmd(1, 0);
        expect_out(6'h0C, 1'b1, "R1 ringing");
        pulse_zc();
        expect_out(6'h0C, 1'b1, "R5 zc while ringing keeps access");
        set_cmd(0, 0);
        expect_out(6'h0B, 1'b1, "R6 make-before-break");
        set_cmd(0, 1);
        expect_out(6'h38, 1'b1, "R5 access lingers without zc");
        pulse_zc();
        expect_out(6'h30, 1'b1, "R5 access releases on zc");

        set_cmd(0, 0);
        expect_out(6'h03, 1'b1, "R3 transparent");
        hold = 1'b1; settle();
        set_cmd(1, 0);
        expect_out(6'h03, 1'b1, "R3 held command ignores change");
        set_cmd(0, 1);
        expect_out(6'h03, 1'b1, "R3 held second change");
        ovr_n = 1'b0; settle();
        expect_out(6'h00, 1'b1, "R4 override bypasses hold");
        ovr_n = 1'b1; settle();
        hold = 1'b0; settle();
        expect_out(6'h30, 1'b1, "R3 release follows input");

        set_cmd(1, 0);
        ovr_n = 1'b0; settle();
        expect_out(6'h08, 1'b1, "R4 override, ring access waits");
        pulse_zc();
        expect_out(6'h00, 1'b1, "R4 override all off after zc");
        ovr_n = 1'b1; settle();
        expect_out(6'h0C, 1'b1, "R4 override released");
        set_cmd(0, 0);
        pulse_zc();
        expect_out(6'h03, 1'b1, "R6 idle after zc");

        therm = 1'b1; settle();
        expect_out(6'h00, 1'b0, "R8 thermal all off");
        compare({sw_nt, sd_nt}, {6'h03, 1'b1}, "R9 thermal disabled");
        therm = 1'b0; settle();
        expect_out(6'h03, 1'b1, "R8 thermal resume");

        bat_high = 1'b1; settle();
        expect_out(6'h00, 1'b1, "R7 battery high off");
        bat_high = 1'b0; settle();
        expect_out(6'h00, 1'b1, "R7 hysteresis holds off");
        pulse_ok();
        expect_out(6'h03, 1'b1, "R7 battery restored");
        bat_lost = 1'b1; settle();
        expect_out(6'h00, 1'b1, "R7 battery lost off");
        bat_lost = 1'b0; settle();
        expect_out(6'h00, 1'b1, "R7 lost hold");
        pulse_ok();
        expect_out(6'h03, 1'b1, "R7 lost restored");
        compare({sw_nt, sd_nt}, {6'h03, 1'b1}, "R9 no-thermal variant idle");

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule